// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of eight units owns a shared bus. It does not use one central priority encoder. It sends a single grant token into unit 0. Each unit stage then makes a local choice: if it has a request waiting it takes the token, and if not it passes the token to the next unit. So a lower chain position always wins over a higher one. The stage that takes the token becomes the bus owner and holds the shared busy line high. While busy is high the token source stays off, so no other unit can win.

Each unit raises its request line for one or more cycles. The stage remembers the request until the unit wins a round. The owner gives up the bus with a one-cycle done pulse. Busy then falls, and if any request is waiting the token enters unit 0 again in the following cycle. The bench watches the token at every link of the chain (chain bits) along with the owner flags.

Top module: `daisy_arbiter`

## Requirements
- R1: `rst` is synchronous and active high. After a reset edge, `taken` is zero, `busy` is low, and every remembered request is cleared, so `chain[0]` stays low until a new request arrives.
- R2: `chain[0]` (the token the arbiter injects) is high only when `busy` is low and at least one request is pending. A request counts as pending if it is remembered or is on `req` in the same cycle. Otherwise `chain[0]` is low.
- R3: Stage i drives `chain[i+1]` high only when `chain[i]` is high and unit i has no pending request. While the token enters, `chain` therefore reads ones from bit 0 up to the winning unit and zeros above it.
- R4: When the token enters, the lowest-numbered pending unit wins. `taken` becomes one-hot on that unit's bit at the next clock edge.
- R5: `taken` is one-hot or zero, and `busy` is high exactly while one bit of `taken` is set.
- R6: While `busy` is high, no other unit gains ownership and a lower-numbered request does not preempt the owner. Requests raised during that time are remembered and take part in the next round.
- R7: A `done` pulse on the owner's bit clears `taken` and `busy` at the next edge. If requests are pending, the next owner takes the bus one edge after that.
- R8: A `done` bit for a unit that does not own the bus has no effect.
- R9: Winning clears the winner's remembered request. A new request from the owner during its own tenure is remembered for a later round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 8 | Per-unit request, remembered until served |
| done | input | 8 | Per-unit release pulse, honoured only from the owner |
| chain | output | 9 | Token at each link; bit 0 from the arbiter, bit i+1 forwarded by stage i |
| taken | output | 8 | Per-unit ownership flag |
| busy | output | 1 | Shared bus-in-use line |

## Verification
The chain bits are combinational. They are checked one nanosecond after inputs change at the falling edge, within the same cycle. `taken` and `busy` are registered, so they are checked at the falling edge after the rising edge that captured the request or the release. After a release the bench first checks the idle gap cycle, with `busy` low and the token entering. It then checks the new owner one cycle later. Requests and releases are driven only at falling edges, so no check depends on the order of processes at the rising edge.

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int UNITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [UNITS-1:0] req,
  input  logic [UNITS-1:0] done,
  output logic [UNITS:0]   chain,
  output logic [UNITS-1:0] taken,
  output logic             busy
);

  logic [UNITS-1:0] held_q;
  logic [UNITS-1:0] want;
  logic [UNITS-1:0] grab;

  assign want     = held_q | req;
  assign busy     = |taken;
  assign chain[0] = ~busy & (|want);

  for (genvar i = 0; i < UNITS; i++) begin : g_stage
    assign grab[i]    = chain[i] & want[i];
    assign chain[i+1] = chain[i] & ~want[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      taken  <= '0;
    end else begin
      held_q <= want & ~grab;
      taken  <= (taken & ~done) | grab;
    end
  end

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(taken));

  p_win_on_request_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && (|want)) |=> busy);

  p_stay_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && want == '0) |=> !busy);

  p_no_steal_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && (done & taken) == '0) |=> taken == $past(taken));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && (done & taken) != '0) |=> !busy);

endmodule

// File: tb/tb_daisy_arbiter.sv
`timescale 1ns/1ps
module tb_daisy_arbiter;
  localparam int U = 8;
  localparam int NV = 8;
  localparam logic [U-1:0] VEC [NV] = '{8'h01, 8'h80, 8'hA4, 8'hFF,
                                        8'h60, 8'h18, 8'h82, 8'h55};
  localparam int EXP [NV] = '{0, 7, 2, 0, 5, 3, 1, 0};

  logic clk = 0;
  logic rst;
  logic [U-1:0] req, done;
  logic [U:0] chain;
  logic [U-1:0] taken;
  logic busy;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  daisy_arbiter #(.UNITS(U)) dut (.clk(clk), .rst(rst), .req(req), .done(done),
    .chain(chain), .taken(taken), .busy(busy));

  function automatic int lowest(logic [U-1:0] v);
    for (int i = 0; i < U; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [U:0] chain_for(int w);
    return (w < 0) ? '0 : (U+1)'((1 << (w + 1)) - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req = '0; done = '0;
    step(); step();
    rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; req = '0; done = '0;
    do_reset();
    chk("R1 taken after reset", 32'(taken), 0);
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 chain idle after reset", 32'(chain), 0);

    for (int v = 0; v < NV; v++) begin
      logic [U-1:0] rem;
      int w;
      do_reset();
      rem = VEC[v];
      w = EXP[v];
      chk("R4 table winner", 32'(lowest(rem)), 32'(w));
      req = rem;
      #1;
      chk("R3 chain ripple", 32'(chain), 32'(chain_for(w)));
      step();
      req = '0;
      chk("R4 first owner", 32'(taken), 32'(1 << w));
      chk("R5 busy with owner", 32'(busy), 1);
      rem[w] = 1'b0;
      while (1) begin
        done = taken;
        step();
        done = '0;
        #1;
        chk("R7 release clears taken", 32'(taken), 0);
        chk("R7 release clears busy", 32'(busy), 0);
        chk("R2 token on idle", 32'(chain[0]), 32'(rem != 0));
        chk("R3 chain after release", 32'(chain), 32'(chain_for(lowest(rem))));
        if (rem == 0) break;
        w = lowest(rem);
        step();
        chk("R4 next owner", 32'(taken), 32'(1 << w));
        rem[w] = 1'b0;
      end
    end

    do_reset();
    req = 8'h10;
    step();
    req = 8'h01;
    #1;
    chk("R2 no token while busy", 32'(chain[0]), 0);
    step();
    req = '0;
    chk("R6 no preemption", 32'(taken), 32'h10);
    step();
    chk("R6 owner kept", 32'(taken), 32'h10);
    done = 8'h10;
    step();
    done = '0;
    step();
    chk("R6 held request served", 32'(taken), 32'h01);

    done = 8'hFE;
    step();
    done = '0;
    chk("R8 foreign done ignored", 32'(taken), 32'h01);
    chk("R8 busy kept", 32'(busy), 1);

    req = 8'h01;
    step();
    req = '0;
    done = 8'h01;
    step();
    done = '0;
    #1;
    chk("R9 own re-request pending", 32'(chain[0]), 1);
    step();
    chk("R9 owner wins again", 32'(taken), 32'h01);

    req = 8'h42;
    step();
    req = '0;
    rst = 1;
    step();
    rst = 0;
    #1;
    chk("R1 reset drops owner", 32'(taken), 0);
    chk("R1 reset clears pending", 32'(chain[0]), 0);
    step();
    chk("R1 stays idle", 32'(busy), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule